// File: doc/BRIEF.md
# Profiling Sample Filter Unit

This block sits between a processor pipeline's profiling sampler and the logic that writes sample records. For every sample the pipeline offers, it decides whether to keep it or discard it. A writable control word selects which filters are active: minimum latency, operation type, required events, forbidden events and load data source. The thresholds and bitmaps that those filters compare against come in on separate inputs.

The type filter combines two kinds of term. The first is an OR group: the sample is accepted if it belongs to any of the listed types. The second is a set of exact-match terms, where the sample must be, or must not be, of a given type. A per-type mask bit chooses which kind of term that type contributes.

The block accepts one sample per clock cycle. Its keep/discard verdict leaves a register stage one cycle later.

Top module: `prof_sample_filter`

## Requirements
- R1: `outValid` rises exactly one clock after a cycle with `smpValid` high and is low one clock after a cycle with `smpValid` low. `outRecord` is low whenever `outValid` is low. Samples may arrive on back-to-back cycles.
- R2: A sample is kept only if every enabled filter passes. A disabled filter always passes, so with the control word at zero every sample is kept.
- R3: With the latency enable (control bit 0) set and `minLatency` nonzero, a sample is discarded when `smpLatency < minLatency`. A latency equal to the minimum is kept. With `minLatency` zero the latency filter passes every sample.
- R4: Type flags use bit 0 for branch, 1 for load, 2 for store, 3 for floating point and 4 for SIMD. With the type enable (control bit 1) set, each type whose mask bit (control bits 20:16) is 0 and whose value bit (control bits 12:8) is 1 joins the OR group. The group passes if the sample carries any of those types.
- R5: With the type enable set, each type whose mask bit is 1 is an exact-match term. A value bit of 1 requires the sample to have that type flag, and a value bit of 0 requires the flag to be absent. All such terms are ANDed with the OR group.
- R6: While the type enable is 0, the type value and mask bits have no effect on the verdict.
- R7: With the type enable set and no type in the OR group, the OR group passes. With no value or mask bit set at all, the type filter passes every sample.
- R8: With the event enable (control bit 2) set, a sample is discarded unless it carries every event set in `evtSelect`.
- R9: With the inverted-event enable (control bit 3) set, a sample carrying any event set in `invEvtSelect` is discarded.
- R10: With the data-source enable (control bit 4) set, a load sample with `smpHasSrc` high is discarded unless bit `smpSrc` of `srcSelect` is set. An all-zero `srcSelect` therefore drops every load that has a source. Loads without a source and all non-load samples are unaffected.
- R11: The control word resets to zero. Only bits 4:0, 12:8 and 20:16 are stored, and all other bits read back as zero. A write affects samples from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Write strobe for the control word |
| cfgWrData | input | 32 | Control word write data |
| cfgRdData | output | 32 | Stored control word |
| minLatency | input | LAT_W | Minimum total latency for the latency filter |
| evtSelect | input | EVT_W | Events a sample must all carry |
| invEvtSelect | input | EVT_W | Events that cause a sample to be discarded |
| srcSelect | input | 2**SRC_W | Accepted load data sources |
| smpValid | input | 1 | A sample is present this cycle |
| smpType | input | 5 | Sample type flags |
| smpEvents | input | EVT_W | Events carried by the sample |
| smpLatency | input | LAT_W | Total latency of the sample |
| smpHasSrc | input | 1 | The sample reports a data source |
| smpSrc | input | SRC_W | Data source index |
| outValid | output | 1 | A verdict is present this cycle |
| outRecord | output | 1 | Keep the sample (1) or discard it (0) |

## Verification
A bit stuck or lost in the stored control word shows up in two places. It is visible on `cfgRdData` one cycle after the write. It also changes the verdict of the first sample whose filtering depends on that bit. A wrong filter term, such as a reversed comparison, a swapped AND/OR role or an unguarded data-source check, corrupts `outRecord` in the cycle right after the affected sample. Random configurations and samples are compared against a bench model. Directed cases target each threshold edge and each degenerate setting.

// File: rtl/psf_pkg.sv
package psf_pkg;
  localparam int NUM_TYPES = 5;
  localparam int TY_BRANCH = 0;
  localparam int TY_LOAD   = 1;
  localparam int TY_STORE  = 2;
  localparam int TY_FP     = 3;
  localparam int TY_SIMD   = 4;

  localparam int CFG_W      = 32;
  localparam int BIT_LAT    = 0;
  localparam int BIT_TYPE   = 1;
  localparam int BIT_EVT    = 2;
  localparam int BIT_INV    = 3;
  localparam int BIT_SRC    = 4;
  localparam int VAL_LSB    = 8;
  localparam int MASK_LSB   = 16;
  localparam logic [CFG_W-1:0] CFG_WRITABLE = 32'h001F_1F1F;

  typedef struct packed {
    logic                 smpStrobe;
    logic                 latEn;
    logic                 typeEn;
    logic                 evtEn;
    logic                 invEn;
    logic                 srcEn;
    logic [NUM_TYPES-1:0] typeVal;
    logic [NUM_TYPES-1:0] typeMask;
  } psf_ctrl_t;
endpackage

// File: rtl/psf_ctrl.sv
module psf_ctrl
  import psf_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic             smpValid,
  output logic [CFG_W-1:0] cfgRdData,
  output psf_ctrl_t        ctrl
);
  logic [CFG_W-1:0] cfgReg;

  always_ff @(posedge clk) begin
    if (!rstN)        cfgReg <= '0;
    else if (cfgWrEn) cfgReg <= cfgWrData & CFG_WRITABLE;
  end

  assign cfgRdData = cfgReg;

  always_comb begin
    ctrl.smpStrobe = smpValid;
    ctrl.latEn     = cfgReg[BIT_LAT];
    ctrl.typeEn    = cfgReg[BIT_TYPE];
    ctrl.evtEn     = cfgReg[BIT_EVT];
    ctrl.invEn     = cfgReg[BIT_INV];
    ctrl.srcEn     = cfgReg[BIT_SRC];
    ctrl.typeVal   = cfgReg[VAL_LSB +: NUM_TYPES];
    ctrl.typeMask  = cfgReg[MASK_LSB +: NUM_TYPES];
  end

  // R11: reserved bits never appear on readback
  p_reserved_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdData & ~CFG_WRITABLE) == '0);

  // R11: a write lands the masked data one cycle later
  p_write_lands_r11: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> cfgRdData == ($past(cfgWrData) & CFG_WRITABLE));
endmodule

// File: rtl/psf_datapath.sv
module psf_datapath
  import psf_pkg::*;
#(
  parameter int LAT_W = 12,
  parameter int EVT_W = 8,
  parameter int SRC_W = 4,
  localparam int SRC_N = 1 << SRC_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  psf_ctrl_t            ctrl,
  input  logic [LAT_W-1:0]     minLatency,
  input  logic [EVT_W-1:0]     evtSelect,
  input  logic [EVT_W-1:0]     invEvtSelect,
  input  logic [SRC_N-1:0]     srcSelect,
  input  logic [NUM_TYPES-1:0] smpType,
  input  logic [EVT_W-1:0]     smpEvents,
  input  logic [LAT_W-1:0]     smpLatency,
  input  logic                 smpHasSrc,
  input  logic [SRC_W-1:0]     smpSrc,
  output logic                 outValid,
  output logic                 outRecord
);
  logic [NUM_TYPES-1:0] orMembers;
  logic [NUM_TYPES-1:0] exactOk;
  logic latPass, orPass, typePass, evtPass, invPass, srcPass, keep;

  assign orMembers = ctrl.typeVal & ~ctrl.typeMask;

  for (genvar i = 0; i < NUM_TYPES; i++) begin : g_exact
    assign exactOk[i] = !ctrl.typeMask[i] || (smpType[i] == ctrl.typeVal[i]);
  end

  always_comb begin
    latPass  = !ctrl.latEn || (minLatency == '0) || (smpLatency >= minLatency);
    orPass   = (orMembers == '0) || ((orMembers & smpType) != '0);
    typePass = !ctrl.typeEn || (orPass && (&exactOk));
    evtPass  = !ctrl.evtEn || ((smpEvents & evtSelect) == evtSelect);
    invPass  = !ctrl.invEn || ((smpEvents & invEvtSelect) == '0);
    srcPass  = !ctrl.srcEn || !smpType[TY_LOAD] || !smpHasSrc || srcSelect[smpSrc];
    keep     = latPass && typePass && evtPass && invPass && srcPass;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outRecord <= 1'b0;
    end else begin
      outValid  <= ctrl.smpStrobe;
      outRecord <= ctrl.smpStrobe && keep;
    end
  end

  // R1: verdict follows the sample by one cycle
  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.smpStrobe |=> outValid);
  p_idle_follows_r1: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.smpStrobe |=> !outValid);
  p_record_needs_valid_r1: assert property (@(posedge clk) disable iff (!rstN)
    outRecord |-> outValid);
  // R2: with no filter enabled, every sample is kept
  p_no_filter_keeps_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.smpStrobe && !ctrl.latEn && !ctrl.typeEn && !ctrl.evtEn && !ctrl.invEn && !ctrl.srcEn)
    |=> outRecord);
  // R3: short samples are discarded
  p_short_dropped_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.smpStrobe && ctrl.latEn && smpLatency < minLatency) |=> !outRecord);
  // R9: forbidden events discard
  p_forbidden_dropped_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.smpStrobe && ctrl.invEn && (smpEvents & invEvtSelect) != '0) |=> !outRecord);
  // R10: non-load samples never fail the source filter
  p_nonload_src_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.smpStrobe && !ctrl.latEn && !ctrl.typeEn && !ctrl.evtEn && !ctrl.invEn
     && !smpType[TY_LOAD]) |=> outRecord);
endmodule

// File: rtl/prof_sample_filter.sv
module prof_sample_filter
  import psf_pkg::*;
#(
  parameter int LAT_W = 12,
  parameter int EVT_W = 8,
  parameter int SRC_W = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgWrEn,
  input  logic [31:0]            cfgWrData,
  output logic [31:0]            cfgRdData,
  input  logic [LAT_W-1:0]       minLatency,
  input  logic [EVT_W-1:0]       evtSelect,
  input  logic [EVT_W-1:0]       invEvtSelect,
  input  logic [(1<<SRC_W)-1:0]  srcSelect,
  input  logic                   smpValid,
  input  logic [4:0]             smpType,
  input  logic [EVT_W-1:0]       smpEvents,
  input  logic [LAT_W-1:0]       smpLatency,
  input  logic                   smpHasSrc,
  input  logic [SRC_W-1:0]       smpSrc,
  output logic                   outValid,
  output logic                   outRecord
);
  psf_ctrl_t ctrl;

  psf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .smpValid(smpValid), .cfgRdData(cfgRdData), .ctrl(ctrl)
  );

  psf_datapath #(.LAT_W(LAT_W), .EVT_W(EVT_W), .SRC_W(SRC_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .minLatency(minLatency), .evtSelect(evtSelect), .invEvtSelect(invEvtSelect),
    .srcSelect(srcSelect), .smpType(smpType), .smpEvents(smpEvents),
    .smpLatency(smpLatency), .smpHasSrc(smpHasSrc), .smpSrc(smpSrc),
    .outValid(outValid), .outRecord(outRecord)
  );
endmodule

// File: tb/prof_sample_filter_tb.sv
`timescale 1ns/1ps
module prof_sample_filter_tb;
  localparam int LAT_W = 12;
  localparam int EVT_W = 8;
  localparam int SRC_W = 4;
  localparam int SRC_N = 1 << SRC_W;
  localparam logic [31:0] WMASK = 32'h001F_1F1F;
  localparam logic [4:0] T_BR = 5'b00001, T_LD = 5'b00010, T_ST = 5'b00100,
                         T_FP = 5'b01000, T_SIMD = 5'b10000;

  logic clk = 0, rstN = 0, cfgWrEn = 0;
  logic [31:0] cfgWrData = '0, cfgRdData;
  logic [LAT_W-1:0] minLatency = '0, smpLatency = '0;
  logic [EVT_W-1:0] evtSelect = '0, invEvtSelect = '0, smpEvents = '0;
  logic [SRC_N-1:0] srcSelect = '0;
  logic smpValid = 0, smpHasSrc = 0, outValid, outRecord;
  logic [4:0] smpType = '0;
  logic [SRC_W-1:0] smpSrc = '0;
  logic [31:0] shadow = '0;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  prof_sample_filter #(.LAT_W(LAT_W), .EVT_W(EVT_W), .SRC_W(SRC_W)) u_dut (.*);

  function automatic bit model(input logic [31:0] c);
    logic [4:0] val, msk, orm;
    bit lp, tp, ep, ip, sp;
    val = c[12:8]; msk = c[20:16]; orm = val & ~msk;
    lp = !c[0] || minLatency == 0 || smpLatency >= minLatency;
    tp = 1;
    if (c[1]) begin
      if (orm != 0 && (orm & smpType) == 0) tp = 0;
      for (int i = 0; i < 5; i++)
        if (msk[i] && smpType[i] != val[i]) tp = 0;
    end
    ep = !c[2] || (smpEvents & evtSelect) == evtSelect;
    ip = !c[3] || (smpEvents & invEvtSelect) == 0;
    sp = !c[4] || !smpType[1] || !smpHasSrc || srcSelect[smpSrc];
    return lp && tp && ep && ip && sp;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [31:0] d);
    @(negedge clk);
    smpValid = 0; cfgWrEn = 1; cfgWrData = d;
    @(posedge clk); #1;
    cfgWrEn = 0; shadow = d & WMASK;
  endtask

  task automatic trySample(input logic [4:0] ty, input logic [EVT_W-1:0] ev,
                           input int lat, input bit hs, input int src,
                           input bit exp, input string tag);
    @(negedge clk);
    smpValid = 1; smpType = ty; smpEvents = ev; smpLatency = LAT_W'(lat);
    smpHasSrc = hs; smpSrc = SRC_W'(src);
    @(posedge clk); #1;
    check({tag, " valid"}, {31'b0, outValid}, 32'd1);
    check(tag, {31'b0, outRecord}, {31'b0, exp});
    smpValid = 0;
  endtask

  initial begin
    #900000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    check("R11 reset cfg", cfgRdData, 32'h0);
    check("R1 reset valid", {31'b0, outValid}, 32'h0);
    @(negedge clk); rstN = 1;

    writeCfg(32'hFFFF_FFFF);
    check("R11 reserved", cfgRdData, WMASK);
    writeCfg(32'h0);
    trySample(T_BR, 8'h00, 0, 0, 0, 1, "R2 all off");
    @(posedge clk); #1;
    check("R1 idle valid", {31'b0, outValid}, 32'h0);
    check("R1 idle record", {31'b0, outRecord}, 32'h0);

    minLatency = 10; writeCfg(32'h1);
    trySample(T_LD, 8'h00, 9, 0, 0, 0, "R3 below min");
    trySample(T_LD, 8'h00, 10, 0, 0, 1, "R3 equal min");
    minLatency = 0; writeCfg(32'h1);
    trySample(T_LD, 8'h00, 0, 0, 0, 1, "R3 min zero");

    writeCfg(32'h2 | (32'(T_LD | T_ST) << 8));
    trySample(T_LD, 8'h00, 0, 0, 0, 1, "R4 load in group");
    trySample(T_BR, 8'h00, 0, 0, 0, 0, "R4 branch outside");

    writeCfg(32'h2 | (32'(T_LD | T_FP) << 8) | (32'(T_FP | T_SIMD) << 16));
    trySample(T_LD | T_FP, 8'h00, 0, 0, 0, 1, "R5 load fp");
    trySample(T_LD, 8'h00, 0, 0, 0, 0, "R5 missing fp");
    trySample(T_LD | T_FP | T_SIMD, 8'h00, 0, 0, 0, 0, "R5 simd excluded");

    writeCfg((32'(T_LD) << 8) | (32'(T_FP) << 16));
    trySample(T_BR, 8'h00, 0, 0, 0, 1, "R6 type off");

    writeCfg(32'h2);
    trySample(T_SIMD, 8'h00, 0, 0, 0, 1, "R7 nothing selected");
    writeCfg(32'h2 | (32'(T_FP) << 8) | (32'(T_FP) << 16));
    trySample(T_FP, 8'h00, 0, 0, 0, 1, "R7 empty or group");

    evtSelect = 8'h05; writeCfg(32'h4);
    trySample(T_BR, 8'h07, 0, 0, 0, 1, "R8 all events");
    trySample(T_BR, 8'h04, 0, 0, 0, 0, "R8 missing event");

    invEvtSelect = 8'h08; writeCfg(32'h8);
    trySample(T_BR, 8'h09, 0, 0, 0, 0, "R9 forbidden");
    trySample(T_BR, 8'h01, 0, 0, 0, 1, "R9 clean");

    srcSelect = 16'h0008; writeCfg(32'h10);
    trySample(T_LD, 8'h00, 0, 1, 3, 1, "R10 selected src");
    trySample(T_LD, 8'h00, 0, 1, 2, 0, "R10 other src");
    trySample(T_LD, 8'h00, 0, 0, 2, 1, "R10 no src");
    trySample(T_ST, 8'h00, 0, 1, 2, 1, "R10 store");
    srcSelect = '0; writeCfg(32'h10);
    trySample(T_LD, 8'h00, 0, 1, 3, 0, "R10 empty select");

    // R2 random configurations against the bench model, back to back
    for (int blk = 0; blk < 40; blk++) begin
      minLatency   = LAT_W'($urandom_range(0, 40));
      evtSelect    = EVT_W'($urandom & $urandom & $urandom);
      invEvtSelect = EVT_W'($urandom & $urandom & $urandom);
      srcSelect    = SRC_N'($urandom);
      writeCfg($urandom);
      for (int n = 0; n < 50; n++) begin
        bit e;
        @(negedge clk);
        smpValid = 1; smpType = 5'($urandom); smpEvents = EVT_W'($urandom);
        smpLatency = LAT_W'($urandom_range(0, 63)); smpHasSrc = 1'($urandom);
        smpSrc = SRC_W'($urandom);
        e = model(shadow);
        @(posedge clk); #1;
        check("R2 random valid", {31'b0, outValid}, 32'd1);
        check("R2 random record", {31'b0, outRecord}, {31'b0, e});
      end
    end
    smpValid = 0;
    @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule